// File: doc/BRIEF.md
# Prioritised Interrupt Vector Responder

This block answers an interrupt acknowledge cycle with an 8-bit vector. The lower nibble of that vector is the number of the highest-numbered channel whose pending bit is set. The upper nibble is a pointer that software writes. The pending-status bits come from outside the block, because condition detection and status clearing belong to a neighbouring block. The responder raises a request line while any pending bit is set. Once the winning channel has been cleared, the next acknowledge returns the next channel in priority order.

A 16-bit register port reads and writes the pointer nibble, and reads also return the live winning channel number. The acknowledge interface and the register port use the same strobe handshake. The block samples the strobe, inserts exactly one wait state and then returns a single-cycle ack. The vector is captured at the first edge of an acknowledge and held until the strobe is released. An acknowledge that selects request 1 is still completed, but returns all-ones because that request is never raised.

Top module: `irq_vector_responder`

## Requirements
- R1: The acknowledge vector bits 3:0 hold the index of the highest-numbered set bit of `pend_i`. Channel NCH-1 wins over every lower channel.
- R2: Vector bits 7:4 hold the pointer nibble, which is written from `reg_wdata_i[7:4]` by a register write. The pointer resets to 0.
- R3: A register read returns 0 in bits 15:12, ones in bits 11:8, the pointer in bits 7:4 and the current winning channel in bits 3:0. A write to any bit outside 7:4 has no effect.
- R4: On both ports, an access is a strobe held high until ack. The ack is high for exactly one cycle, and it appears after the second rising edge at which the strobe is sampled high (one wait state).
- R5: The acknowledge vector is captured at the first edge where the strobe is sampled high. It is then held unchanged until the strobe drops, even if `pend_i` changes meanwhile.
- R6: An acknowledge with `iack_req_i` high (request 1) is acked and returns 8'hFF.
- R7: An acknowledge when no channel is pending is still acked, and its low nibble is 0.
- R8: `irq_o` equals the OR of `pend_i` one clock later. After the winner is cleared, the next acknowledge returns the next-highest pending channel.
- R9: After reset, `irq_o`, both acks and the pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | NCH | Pending-status bit per channel |
| irq_o | output | 1 | Interrupt request 0 |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| reg_ack_o | output | 1 | Register access ack |
| iack_sel_i | input | 1 | Interrupt acknowledge strobe |
| iack_req_i | input | 1 | Request select: 0 = request 0, 1 = request 1 |
| iack_data_o | output | VEC_W | Acknowledge vector |
| iack_ack_o | output | 1 | Acknowledge ack |

## Verification
The bench builds the block with the default parameters: 12 channels, an 8-bit vector, a 16-bit register and one wait state. With 12 channels, both ends of the priority order can be reached, channel 11 over every other and channel 0 alone. The bench walks a pending set down through three clears and changes the pending bits in the middle of a held acknowledge. With a single wait state, every ack lands at a fixed cycle offset, so the bench can count that offset exactly.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2,
    HS_HOLD = 2'd3
  } hs_state_e;

  localparam logic [3:0] REG_TOP_NIB = 4'h0;
  localparam logic [3:0] REG_MID_NIB = 4'hF;
endpackage

// File: rtl/ivr_prio_enc.sv
module ivr_prio_enc #(
  parameter int NCH   = 12,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // ascending scan: last hit is the highest channel
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/ivr_handshake.sv
module ivr_handshake
  import ivr_pkg::*;
#(
  parameter int WAIT_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic start_o,
  output logic ack_o
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      HS_IDLE: if (sel_i) begin
        state_d = HS_WAIT;
        cnt_d   = '0;
      end
      HS_WAIT: begin
        if (cnt_q == CNT_LAST) state_d = HS_ACK;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      HS_ACK:  state_d = sel_i ? HS_HOLD : HS_IDLE;
      HS_HOLD: if (!sel_i) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign start_o = (state_q == HS_IDLE) && sel_i;
  assign ack_o   = (state_q == HS_ACK);
endmodule

// File: rtl/ivr_vec_reg.sv
module ivr_vec_reg
  import ivr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [NIB_W-1:0]  ptr_wr_i,
  input  logic [NIB_W-1:0]  win_i,
  output logic [NIB_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NIB_W-1:0]  ptr_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      rdata_q <= DATA_W'({REG_TOP_NIB, REG_MID_NIB, ptr_q, win_i});
      if (we_i) ptr_q <= ptr_wr_i;
    end
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder #(
  parameter int NCH      = 12,
  parameter int VEC_W    = 8,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    pend_i,
  output logic              irq_o,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_ack_o,
  input  logic              iack_sel_i,
  input  logic              iack_req_i,
  output logic [VEC_W-1:0]  iack_data_o,
  output logic              iack_ack_o
);
  localparam int NIB_W = VEC_W / 2;
  localparam int IDX_W = (NCH < 2) ? 1 : $clog2(NCH);

  logic [IDX_W-1:0] win_idx;
  logic             win_any;
  logic [NIB_W-1:0] win_nib, ptr;
  logic             reg_start, iack_start;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;

  ivr_prio_enc #(.NCH(NCH), .IDX_W(IDX_W)) u_enc (
    .req_i (pend_i),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  assign win_nib = NIB_W'(win_idx);

  ivr_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (reg_sel_i),
    .start_o (reg_start),
    .ack_o   (reg_ack_o)
  );

  ivr_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs_iack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (iack_sel_i),
    .start_o (iack_start),
    .ack_o   (iack_ack_o)
  );

  ivr_vec_reg #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_vreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (reg_start),
    .we_i     (reg_we_i),
    .ptr_wr_i (reg_wdata_i[2*NIB_W-1:NIB_W]),
    .win_i    (win_nib),
    .ptr_o    (ptr),
    .rdata_o  (reg_rdata_o)
  );

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[DATA_W-1:2*NIB_W], reg_wdata_i[NIB_W-1:0]};

  // vector frozen at the first strobe edge; request 1 never raised -> all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= win_any;
      if (iack_start) begin
        if (iack_req_i) vec_q <= '1;
        else            vec_q <= {ptr, win_any ? win_nib : NIB_W'(0)};
      end
    end
  end

  assign irq_o       = irq_q;
  assign iack_data_o = vec_q;
endmodule

// File: rtl/irq_vector_responder_chk.sv
module irq_vector_responder_chk #(
  parameter int NCH    = 12,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    pend_i,
  input logic              irq_o,
  input logic              reg_sel_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              reg_ack_o,
  input logic              iack_sel_i,
  input logic              iack_req_i,
  input logic [VEC_W-1:0]  iack_data_o,
  input logic              iack_ack_o
);
  localparam int NIB_W = VEC_W / 2;

  assert_iack_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_ack_o |=> !iack_ack_o);
  assert_reg_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ack_o |=> !reg_ack_o);
  assert_iack_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iack_ack_o) |-> ($past(iack_sel_i) && $past(iack_sel_i, 2)));
  assert_vec_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_sel_i && $past(iack_sel_i) && $past(iack_sel_i, 2)) |-> $stable(iack_data_o));
  assert_req1_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_ack_o && iack_req_i) |-> (iack_data_o == '1));
  assert_nib_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_ack_o && !iack_req_i) |-> (int'(iack_data_o[NIB_W-1:0]) < NCH));
  assert_fixed_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ack_o |-> (reg_rdata_o[DATA_W-1:2*NIB_W] == DATA_W'(8'h0F)));
  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_i) |=> irq_o);
  assert_irq_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend_i) |=> !irq_o);

  logic unused_sel;
  assign unused_sel = reg_sel_i;
endmodule

bind irq_vector_responder irq_vector_responder_chk #(
  .NCH(NCH), .VEC_W(VEC_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pend_i      (pend_i),
  .irq_o       (irq_o),
  .reg_sel_i   (reg_sel_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_ack_o   (reg_ack_o),
  .iack_sel_i  (iack_sel_i),
  .iack_req_i  (iack_req_i),
  .iack_data_o (iack_data_o),
  .iack_ack_o  (iack_ack_o)
);

// File: tb/irq_vector_responder_tb.sv
module irq_vector_responder_tb;
  localparam int NCH = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] pend_i = '0;
  logic        irq_o;
  logic        reg_sel_i = 1'b0, reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0, reg_rdata_o;
  logic        reg_ack_o;
  logic        iack_sel_i = 1'b0, iack_req_i = 1'b0;
  logic [7:0]  iack_data_o;
  logic        iack_ack_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_vector_responder u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one acknowledge; optional pend change after first edge
  task automatic do_iack(input logic req, input bit mid, input logic [11:0] mid_pend,
                         output logic [7:0] data, output int waits);
    @(negedge clk_i);
    iack_sel_i = 1'b1;
    iack_req_i = req;
    waits = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      waits++;
      if (mid && k == 0) pend_i = mid_pend;
      if (iack_ack_o) break;
    end
    data = iack_data_o;
    @(negedge clk_i);
    chk("R4 ack single cycle", {31'd0, iack_ack_o}, 32'd0);
    chk("R5 held after ack", {24'd0, iack_data_o}, {24'd0, data});
    iack_sel_i = 1'b0;
    iack_req_i = 1'b0;
  endtask

  task automatic do_reg(input logic we, input logic [15:0] wd,
                        output logic [15:0] rd, output int waits);
    @(negedge clk_i);
    reg_sel_i = 1'b1;
    reg_we_i = we;
    reg_wdata_i = wd;
    waits = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      waits++;
      if (reg_ack_o) break;
    end
    rd = reg_rdata_o;
    reg_sel_i = 1'b0;
    reg_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R9 iack ack after reset", {31'd0, iack_ack_o}, 32'd0);
    chk("R9 reg ack after reset", {31'd0, reg_ack_o}, 32'd0);
  endtask

  task automatic t_empty();
    logic [7:0] d; int w;
    pend_i = '0;
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R7 empty acked wait", w, 2);
    chk("R7 R9 empty vector", {24'd0, d}, 32'h00);
  endtask

  task automatic t_ptr();
    logic [15:0] rd; int w;
    do_reg(1'b1, 16'hFFA7, rd, w);
    chk("R4 reg write wait", w, 2);
    pend_i = 12'b0000_0010_0000;
    @(negedge clk_i);
    do_reg(1'b0, 16'h0, rd, w);
    chk("R3 read layout, write mask", {16'd0, rd}, 32'h0FA5);
  endtask

  task automatic t_prio();
    logic [7:0] d; int w;
    pend_i = 12'hFFF;
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R4 iack wait", w, 2);
    chk("R1 R2 all pending -> 11", {24'd0, d}, 32'hAB);
    pend_i = 12'h001;
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R1 only ch0", {24'd0, d}, 32'hA0);
    pend_i = 12'h851;
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R1 mixed -> 11", {24'd0, d}, 32'hAB);
  endtask

  task automatic t_hold();
    logic [7:0] d; int w;
    pend_i = 12'h020;
    do_iack(1'b0, 1'b1, 12'h800, d, w);
    chk("R5 captured at start", {24'd0, d}, 32'hA5);
  endtask

  task automatic t_req1();
    logic [7:0] d; int w;
    pend_i = 12'h010;
    do_iack(1'b1, 1'b0, '0, d, w);
    chk("R6 req1 acked", w, 2);
    chk("R6 req1 ones", {24'd0, d}, 32'hFF);
  endtask

  task automatic t_next();
    logic [7:0] d; int w;
    pend_i = 12'h288;
    @(negedge clk_i);
    chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R8 first 9", {24'd0, d}, 32'hA9);
    pend_i = 12'h088;
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R8 next 7", {24'd0, d}, 32'hA7);
    pend_i = 12'h008;
    do_iack(1'b0, 1'b0, '0, d, w);
    chk("R8 next 3", {24'd0, d}, 32'hA3);
    pend_i = 12'h000;
    @(negedge clk_i);
    chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    #20;
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_empty();
    t_ptr();
    t_prio();
    t_hold();
    t_req1();
    t_next();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule